// File: doc/BRIEF.md
# Single-to-Double Precision Load Widener

This block sits on the load path of a floating-point register file. It takes the four bytes of a single-precision value as they come back from memory and returns the matching 64-bit double-precision pattern, ready to write into a 64-bit register. The byte from the lowest address is the most significant byte. Every single-precision value has an exact double-precision form, so the widening never rounds and never produces a status flag.

Inside, the assembled word is sorted into one of four operand classes: `CLS_ZERO`, `CLS_SUB`, `CLS_NORM` and `CLS_SPECIAL` (infinity or NaN). A `unique case` over the class selects the output format.
- Normals get a new exponent bias.
- Subnormals are renormalised using a leading-zero count.
- Zeros keep only their sign.
- Specials get the all-ones exponent, and their payload is moved across bit for bit.

There are no transitions between classes: each input is classified on its own.

The parameter `PIPE` chooses between two builds. With `PIPE = 0` the output is combinational. With `PIPE = 1` one register stage follows the converter.

Top module: `widen_s2d`

## Requirements
- R1: `in_bytes[0]` is the byte from the lowest address and supplies bits 31:24 of the single word; `in_bytes[3]` supplies bits 7:0. The output sign bit 63 equals bit 7 of `in_bytes[0]`.
- R2: For a normal input (exponent field 1..254), the output exponent (bits 62:52) is the input exponent plus 896. The output fraction (bits 51:0) is the 23-bit input fraction in bits 51:29, with zeros below.
- R3: A subnormal input (exponent 0, fraction nonzero) becomes a normal double. The leading one of the fraction is shifted out to become implicit, the remaining bits are placed from bit 51 down, and the exponent is 897 minus the shift amount. No flush to zero is applied.
- R4: A zero input of either sign gives a zero output with the same sign: 0x0000000000000000 or 0x8000000000000000.
- R5: An input with exponent field 255 gives exponent 0x7FF with the fraction left-aligned as in R2. This covers infinities and NaNs. A signalling NaN (fraction bit 22 clear) stays signalling (output bit 51 clear), and its payload is unchanged.
- R6: With `PIPE = 0`, `out_valid` and `out_data` follow the inputs in the same cycle. With `PIPE = 1` they appear one clock later, and reset clears `out_valid`.
- R7: The conversion is exact: narrowing any output back to single precision returns the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bytes are valid this cycle |
| in_bytes | input | 32 | Four bytes; element 0 is the lowest address |
| out_valid | output | 1 | Output pattern is valid |
| out_data | output | 64 | Double-precision pattern |

## Verification
The bench builds two copies of the block side by side: `PIPE = 1` as `dut` and `PIPE = 0` as `dut_comb`. Both copies get the same stimulus, so every vector is checked once in the cycle it is applied and once a cycle later. This exposes both the conversion itself and the valid alignment of the register stage. Gaps in `in_valid` check that a bubble does not carry a stale pattern through the registered build.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;
    localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
    localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
    localparam int NBYTES  = SP_W / 8;
    localparam int FRAC_PAD = DP_FRAC - SP_FRAC;
    localparam int SP_BIAS = (1 << (SP_EXP - 1)) - 1;
    localparam int DP_BIAS = (1 << (DP_EXP - 1)) - 1;
    localparam int REBIAS  = DP_BIAS - SP_BIAS;
    localparam int LZ_W    = $clog2(SP_FRAC + 1);

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_SPECIAL
    } cls_e;

    // Reverse conversion, used only by the checks in the top module.
    function automatic logic [SP_W-1:0] narrow(input logic [DP_W-1:0] d);
        logic [DP_EXP-1:0]  e;
        logic [SP_FRAC:0]   mant;
        int                 sh;
        e = d[DP_W-2 -: DP_EXP];
        if (e == {DP_EXP{1'b1}})
            narrow = {d[DP_W-1], {SP_EXP{1'b1}}, d[DP_FRAC-1 -: SP_FRAC]};
        else if (e == '0)
            narrow = {d[DP_W-1], {(SP_W-1){1'b0}}};
        else if (int'(e) > REBIAS)
            narrow = {d[DP_W-1], SP_EXP'(int'(e) - REBIAS), d[DP_FRAC-1 -: SP_FRAC]};
        else begin
            sh   = REBIAS + 1 - int'(e);
            mant = {1'b1, d[DP_FRAC-1 -: SP_FRAC]} >> sh;
            narrow = {d[DP_W-1], {SP_EXP{1'b0}}, mant[SP_FRAC-1:0]};
        end
    endfunction
endpackage

// File: rtl/fpw_classify.sv
module fpw_classify
    import fpw_pkg::*;
(
    input  logic [SP_EXP-1:0]  exp_in,
    input  logic [SP_FRAC-1:0] frac_in,
    output cls_e               cls
);
    logic exp_zero;
    logic exp_ones;
    logic frac_zero;

    always_comb begin
        exp_zero  = (exp_in == '0);
        exp_ones  = (exp_in == {SP_EXP{1'b1}});
        frac_zero = (frac_in == '0);
        unique case ({exp_ones, exp_zero})
            2'b10:   cls = CLS_SPECIAL;
            2'b01:   cls = frac_zero ? CLS_ZERO : CLS_SUB;
            default: cls = CLS_NORM;
        endcase
    end
endmodule

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Scan from the LSB upwards so that the highest set bit wins.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpw_pack.sv
module fpw_pack
    import fpw_pkg::*;
(
    input  logic               sign,
    input  logic [SP_EXP-1:0]  exp_in,
    input  logic [SP_FRAC-1:0] frac_in,
    input  cls_e               cls,
    input  logic [LZ_W-1:0]    lz,
    output logic [DP_W-1:0]    result
);
    logic [LZ_W-1:0]    shift;
    logic [SP_FRAC-1:0] renorm;
    logic [DP_EXP-1:0]  sub_exp;

    always_comb begin
        shift   = lz + LZ_W'(1);
        renorm  = frac_in << shift;
        sub_exp = DP_EXP'(REBIAS + 1) - DP_EXP'(shift);
        unique case (cls)
            CLS_ZERO:    result = {sign, {(DP_W-1){1'b0}}};
            CLS_SUB:     result = {sign, sub_exp, renorm, {FRAC_PAD{1'b0}}};
            CLS_NORM:    result = {sign, DP_EXP'(exp_in) + DP_EXP'(REBIAS),
                                   frac_in, {FRAC_PAD{1'b0}}};
            CLS_SPECIAL: result = {sign, {DP_EXP{1'b1}}, frac_in, {FRAC_PAD{1'b0}}};
            default:     result = '0;
        endcase
    end
endmodule

// File: rtl/widen_s2d.sv
module widen_s2d
    import fpw_pkg::*;
#(
    parameter int PIPE = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NBYTES-1:0][7:0]  in_bytes,
    output logic                    out_valid,
    output logic [DP_W-1:0]         out_data
);
    logic [SP_W-1:0]   word;
    cls_e              cls;
    logic [LZ_W-1:0]   lz;
    logic [DP_W-1:0]   conv;

    // Lowest address lands in the most significant byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
        assign word[(NBYTES-1-b)*8 +: 8] = in_bytes[b];
    end

    fpw_classify u_cls (
        .exp_in  (word[SP_W-2 -: SP_EXP]),
        .frac_in (word[SP_FRAC-1:0]),
        .cls     (cls)
    );

    fpw_lzc #(.W(SP_FRAC), .CW(LZ_W)) u_lzc (
        .vec (word[SP_FRAC-1:0]),
        .cnt (lz)
    );

    fpw_pack u_pack (
        .sign    (word[SP_W-1]),
        .exp_in  (word[SP_W-2 -: SP_EXP]),
        .frac_in (word[SP_FRAC-1:0]),
        .cls     (cls),
        .lz      (lz),
        .result  (conv)
    );

    if (PIPE != 0) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_data <= conv;
            end
        end

        // R6
        valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R6
        bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_data  = conv;
    end

    // R1
    sign_from_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> conv[DP_W-1] == in_bytes[0][7]);
    // R7
    roundtrip_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> narrow(conv) == word);
    // R3
    subnormal_renorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_SUB) |->
            (conv[DP_W-2 -: DP_EXP] != '0) && (int'(conv[DP_W-2 -: DP_EXP]) <= REBIAS));
    // R5
    snan_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_SPECIAL && word[SP_FRAC-1:0] != '0 && !word[SP_FRAC-1])
            |-> (conv[DP_W-2 -: DP_EXP] == {DP_EXP{1'b1}}) && !conv[DP_FRAC-1]);
endmodule

// File: tb/tb_widen_s2d.sv
module tb_widen_s2d;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic             in_valid;
    logic [3:0][7:0]  in_bytes;
    logic             dut_ov, comb_ov;
    logic [63:0]      dut_od, comb_od;

    int errors = 0;
    int checks = 0;

    logic [63:0] pend_data  = '0;
    logic        pend_valid = 1'b0;
    string       pend_req   = "R6";

    widen_s2d #(.PIPE(1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
        .out_valid(dut_ov), .out_data(dut_od));

    widen_s2d #(.PIPE(0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
        .out_valid(comb_ov), .out_data(comb_od));

    function automatic logic [63:0] ref_widen(input logic [31:0] w);
        logic        s;
        int          e;
        longint unsigned f;
        int          p;
        s = w[31];
        e = int'(w[30:23]);
        f = longint'(w[22:0]);
        if (e == 255) return {s, 11'h7FF, w[22:0], 29'b0};
        if (e == 0 && f == 0) return {s, 63'b0};
        if (e == 0) begin
            p = 0;
            for (int i = 0; i < 23; i++) if (f[i]) p = i;
            f = (f - (64'd1 << p)) << (52 - p);
            return {s, 11'(874 + p), f[51:0]};
        end
        return {s, 11'(e + 896), w[22:0], 29'b0};
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s valid: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input string req);
        @(negedge clk);
        // Registered copy: result of the previous step.
        check1(pend_req, dut_ov, pend_valid);
        if (pend_valid) check64(pend_req, dut_od, pend_data);
        in_valid    = v;
        in_bytes[0] = w[31:24];
        in_bytes[1] = w[23:16];
        in_bytes[2] = w[15:8];
        in_bytes[3] = w[7:0];
        #1;
        check1(req, comb_ov, v);
        if (v) check64(req, comb_od, ref_widen(w));
        pend_valid = v;
        pend_data  = ref_widen(w);
        pend_req   = req;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_bytes = '0;
        repeat (3) @(negedge clk);
        check1("R6 reset", dut_ov, 1'b0);
        rst_n = 1'b1;

        // R1: byte order, 1.0 and -2.5
        step(1'b1, 32'h3F800000, "R1");
        check64("R1 anchor", comb_od, 64'h3FF0000000000000);
        step(1'b1, 32'hC0200000, "R1");
        // R4: signed zeros
        step(1'b1, 32'h00000000, "R4");
        check64("R4 anchor", comb_od, 64'h0);
        step(1'b1, 32'h80000000, "R4");
        check64("R4 anchor", comb_od, 64'h8000000000000000);
        // R3: subnormals
        step(1'b1, 32'h00000001, "R3");
        check64("R3 anchor", comb_od, 64'h36A0000000000000);
        step(1'b1, 32'h007FFFFF, "R3");
        step(1'b1, 32'h80400000, "R3");
        step(1'b1, 32'h00012345, "R3");
        // R2: normals
        step(1'b1, 32'h00800000, "R2");
        step(1'b1, 32'h7F7FFFFF, "R2");
        check64("R2 anchor", comb_od, 64'h47EFFFFFE0000000);
        // R6: bubble between vectors
        step(1'b0, 32'h12345678, "R6");
        step(1'b1, 32'h41200000, "R6");
        // R5: infinities and NaNs
        step(1'b1, 32'h7F800000, "R5");
        step(1'b1, 32'hFF800000, "R5");
        check64("R5 anchor", comb_od, 64'hFFF0000000000000);
        step(1'b1, 32'h7FC00001, "R5");
        step(1'b1, 32'h7F800001, "R5");
        check64("R5 anchor", comb_od, 64'h7FF0000020000000);
        check1("R5 snan quiet bit", comb_od[51], 1'b0);
        step(1'b1, 32'hFFA5A5A5, "R5");
        // R7: broad sweep with random gaps
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (n % 4 == 1) r[30:23] = 8'h00;
            if (n % 9 == 2) r[30:23] = 8'hFF;
            step(($urandom % 5) != 0, r, "R7");
        end
        step(1'b0, 32'h0, "R6");
        step(1'b0, 32'h0, "R6");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule